// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Stretch Hold-Off

This block produces the serial clock for an I2C bus master. It drives the clock line open-drain: a single output asks the pad to pull the line low, and releasing it lets the pull-up take the line high. The actual level on the wire comes back through a two-flop synchroniser. A reloadable down-counter times each phase, and it advances once per machine tick. One machine tick is four input clocks. A 7-bit rate value, loaded at the start of every phase, sets the length of both the low phase and the high phase.

When the low phase expires, the block lets go of the line and freezes its counter. It stays there until the synchronised line actually reads high. Then it reloads the counter and times the high interval. A slave that holds the clock low therefore lengthens the period, and it never shortens the high time. The hold-off is the same for every kind of bus activity (start, stop, repeated start, transmit, receive), because this block never sees which one is in progress. Single-cycle strobes mark each rising and falling edge for the byte engine that sits alongside. A status output reports when a slave is stretching the clock.

Top module: `scl_rate_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it rises in the middle of a transfer, `scl_low_o`, `rise_stb_o`, `fall_stb_o` and `stretch_o` are 0 (line released, transfer aborted).
- R2: With no stretching, `scl_low_o` stays 1 for exactly 4*(rate+1) clocks. The rate is the value of `rate_i` at the start of the low phase.
- R3: After a release, the counter is frozen. The high phase starts on the first machine tick at which the synchronised line is high, and it lasts 4*(rate+1) clocks before `scl_low_o` returns to 1.
- R4: When a slave holds the line low after release, the high phase is timed from the moment the line is seen high. From `rise_stb_o` to the next `fall_stb_o` is still exactly 4*(rate+1) clocks.
- R5: `stretch_o` is 1, one clock late, while the line is released but the synchronised line reads low. Otherwise it is 0.
- R6: `fall_stb_o` is a one-clock pulse in the clock where `scl_low_o` goes to 1. `rise_stb_o` is a one-clock pulse when the high phase starts. The two strobes are never high together.
- R7: `en_i` is sampled only on machine ticks. Asserting it while idle starts a low phase. If it is low when a high phase ends, the line stays released and no further falling strobe appears.
- R8: A rate of 0 gives phases of one machine tick (4 clocks).
- R9: With no stretching, `rise_stb_o` follows the release by exactly one machine tick (4 clocks). This tick covers the two-flop synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Start and continue clock generation |
| rate_i | input | 7 | Phase length reload value, in machine ticks minus one |
| scl_in_i | input | 1 | Level read back from the clock line |
| scl_low_o | output | 1 | Pull the clock line low when 1 (open-drain enable) |
| stretch_o | output | 1 | Line released but still held low by a slave |
| rise_stb_o | output | 1 | One-clock strobe at start of high phase |
| fall_stb_o | output | 1 | One-clock strobe when the line is pulled low |

## Verification
Two events can fall on the same machine tick. One is the end of the high phase, with its reload, pull-low and falling strobe. The other is the sampling of the enable for the next period. The same holds at a release where the synchronised line is already high: the release and the reload decision for the high phase meet. The bench reaches both. It drops `en_i` while periods run back to back at the smallest rate, and it lets a stretched line go high in the same tick window that would otherwise have started the next phase. A behavioural model, run in parallel on every clock, judges the drive, strobe and stretch outputs cycle by cycle. Directed measurements check the phase lengths in clocks.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;
endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/scl_sync2.sv
module scl_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/scl_baud_cnt.sv
module scl_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int RATE_W   = 7,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              scl_in_i,
  output logic              scl_low_o,
  output logic              stretch_o,
  output logic              rise_stb_o,
  output logic              fall_stb_o
);
  logic   tick, scl_s, cnt_zero;
  logic   load, dec;
  phase_t ph_q, ph_n;
  logic   low_q, low_n, rise_n, fall_n, stretch_n;
  logic   rise_q, fall_q, stretch_q;

  scl_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  scl_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(scl_in_i), .q_o(scl_s)
  );

  scl_baud_cnt #(.W(RATE_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .dec_i(dec),
    .val_i(rate_i), .zero_o(cnt_zero)
  );

  always_comb begin
    ph_n   = ph_q;
    low_n  = low_q;
    load   = 1'b0;
    dec    = 1'b0;
    rise_n = 1'b0;
    fall_n = 1'b0;
    if (tick) begin
      case (ph_q)
        PH_IDLE: if (en_i) begin
          ph_n = PH_LOW; low_n = 1'b1; load = 1'b1; fall_n = 1'b1;
        end
        PH_LOW: if (cnt_zero) begin
          ph_n = PH_WAIT; low_n = 1'b0;
        end else begin
          dec = 1'b1;
        end
        PH_WAIT: if (scl_s) begin
          ph_n = PH_HIGH; load = 1'b1; rise_n = 1'b1;
        end
        PH_HIGH: if (cnt_zero) begin
          if (en_i) begin
            ph_n = PH_LOW; low_n = 1'b1; load = 1'b1; fall_n = 1'b1;
          end else begin
            ph_n = PH_IDLE;
          end
        end else begin
          dec = 1'b1;
        end
        default: begin
          ph_n = PH_IDLE; low_n = 1'b0;
        end
      endcase
    end
  end

  assign stretch_n = (ph_q == PH_WAIT) && !scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      low_q     <= 1'b0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      ph_q      <= ph_n;
      low_q     <= low_n;
      rise_q    <= rise_n;
      fall_q    <= fall_n;
      stretch_q <= stretch_n;
    end
  end

  assign scl_low_o  = low_q;
  assign rise_stb_o = rise_q;
  assign fall_stb_o = fall_q;
  assign stretch_o  = stretch_q;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk,
  input logic rst,
  input logic scl_low_o,
  input logic stretch_o,
  input logic rise_stb_o,
  input logic fall_stb_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb_o && fall_stb_o)); // R6
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_stb_o |=> !rise_stb_o); // R6
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall_stb_o |=> !fall_stb_o); // R6
  AST_FALL_PULLS: assert property (@(posedge clk) disable iff (rst)
    fall_stb_o |-> scl_low_o); // R6
  AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rise_stb_o |-> !scl_low_o); // R3
  AST_STRETCH_RELEASED: assert property (@(posedge clk) disable iff (rst)
    stretch_o |-> !scl_low_o); // R5
endmodule

bind scl_rate_gen scl_rate_gen_chk chk_i (
  .clk(clk), .rst(rst), .scl_low_o(scl_low_o), .stretch_o(stretch_o),
  .rise_stb_o(rise_stb_o), .fall_stb_o(fall_stb_o)
);

// File: tb/scl_rate_gen_tb_top.sv
module scl_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [6:0] rate = 7'd0;
  logic       hold = 1'b0;
  logic       scl_low, stretch, rise_stb, fall_stb;
  wire        scl_line = !scl_low && !hold;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_gen dut_i (
    .clk(clk), .rst(rst), .en_i(en), .rate_i(rate), .scl_in_i(scl_line),
    .scl_low_o(scl_low), .stretch_o(stretch),
    .rise_stb_o(rise_stb), .fall_stb_o(fall_stb)
  );

  // behavioural reference: phase 0 idle, 1 low, 2 waiting for line, 3 high
  int m_div, m_ph, m_cnt;
  bit m_s1, m_s2, m_low, m_rise, m_fall, m_str;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_div = 0; m_ph = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1;
      m_low = 0; m_rise = 0; m_fall = 0; m_str = 0;
    end else begin
      bit line, tk, n_str;
      line = !m_low && !hold;
      tk = (m_div == 3);
      m_div = (m_div + 1) % 4;
      n_str = (m_ph == 2) && !m_s2;
      m_rise = 0; m_fall = 0;
      if (tk) begin
        if (m_ph == 0) begin
          if (en) begin m_ph = 1; m_low = 1; m_cnt = rate; m_fall = 1; end
        end else if (m_ph == 1) begin
          if (m_cnt == 0) begin m_ph = 2; m_low = 0; end else m_cnt--;
        end else if (m_ph == 2) begin
          if (m_s2) begin m_ph = 3; m_cnt = rate; m_rise = 1; end
        end else begin
          if (m_cnt == 0) begin
            if (en) begin m_ph = 1; m_low = 1; m_cnt = rate; m_fall = 1; end
            else m_ph = 0;
          end else m_cnt--;
        end
      end
      m_s2 = m_s1; m_s1 = line;
      m_str = n_str;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    chk(scl_low  == m_low,  "R3 drive",   scl_low,  m_low);
    chk(stretch  == m_str,  "R5 stretch", stretch,  m_str);
    chk(rise_stb == m_rise, "R6 rise",    rise_stb, m_rise);
    chk(fall_stb == m_fall, "R6 fall",    fall_stb, m_fall);
  end

  always @(posedge clk) begin
    if (cyc >= WD_LIMIT) begin
      failures++;
      checks++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_fall(output int c);
    do @(negedge clk); while (!fall_stb);
    c = cyc;
  endtask
  task automatic wait_rise(output int c);
    do @(negedge clk); while (!rise_stb);
    c = cyc;
  endtask
  task automatic wait_release(output int c);
    do @(negedge clk); while (scl_low);
    c = cyc;
  endtask

  initial begin
    int c0, c1, c2, c3, nf, nr;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!scl_low && !stretch && !rise_stb && !fall_stb, "R1 reset outputs",
        {scl_low, stretch, rise_stb, fall_stb}, 0);
    rst = 1'b0;

    // R2, R9, R3 with no stretching, rate 5
    rate = 7'd5;
    en = 1'b1;
    wait_fall(c0);
    wait_release(c1);
    chk(c1 - c0 == 24, "R2 low length", c1 - c0, 24);
    wait_rise(c2);
    chk(c2 - c1 == 4, "R9 release to rise", c2 - c1, 4);
    wait_fall(c3);
    chk(c3 - c2 == 24, "R3 high length", c3 - c2, 24);

    // R4, R5 slave holds the line low
    rate = 7'd3;
    wait_fall(c0);
    hold = 1'b1;
    wait_release(c1);
    nr = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rise_stb) nr++;
    end
    chk(stretch == 1'b1, "R5 stretch seen", stretch, 1);
    chk(nr == 0, "R3 frozen during hold", nr, 0);
    hold = 1'b0;
    wait_rise(c2);
    chk(c2 - c1 >= 30, "R4 rise after hold", c2 - c1, 30);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(stretch == 1'b0, "R5 stretch cleared", stretch, 0);
    wait_fall(c3);
    chk(c3 - c2 == 16, "R4 high after stretch", c3 - c2, 16);

    // short holds that end near a tick boundary
    for (int k = 1; k < 7; k++) begin
      wait_fall(c0);
      hold = 1'b1;
      wait_release(c1);
      repeat (k) @(negedge clk);
      hold = 1'b0;
      wait_rise(c2);
      wait_fall(c3);
      chk(c3 - c2 == 16, "R4 high length varied hold", c3 - c2, 16);
    end

    // R8 minimum rate
    rate = 7'd0;
    wait_fall(c0);
    wait_fall(c0);
    wait_release(c1);
    chk(c1 - c0 == 4, "R8 low length rate0", c1 - c0, 4);
    wait_rise(c2);
    wait_fall(c3);
    chk(c3 - c2 == 4, "R8 high length rate0", c3 - c2, 4);

    // R7 disable finishes the period and stays released
    en = 1'b0;
    repeat (20) @(negedge clk);
    nf = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (fall_stb || scl_low) nf++;
    end
    chk(nf == 0, "R7 idle after disable", nf, 0);

    // R7 restart, then R1 abort in mid low phase
    rate = 7'd5;
    en = 1'b1;
    wait_fall(c0);
    chk(scl_low == 1'b1, "R7 restart drives low", scl_low, 1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!scl_low && !fall_stb && !rise_stb && !stretch, "R1 abort releases",
        {scl_low, stretch, rise_stb, fall_stb}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule